// File: doc/BRIEF.md
# Processor Bus Interrupt Front End

This block sits between a host processor bus and a serial peripheral. It handles the register side of that peripheral. The host starts a transfer by pulling an active-low select low. A direction line picks read (high) or write (low), and a four-bit address picks the register. The block answers with an active-low transfer acknowledge and holds it until the host lets go of the select.

The block gathers eight interrupt conditions into a status register. A mask register gates them. If any gated condition is present, an active-low request line is pulled low. When the host runs an interrupt-acknowledge cycle, the block puts its vector byte on the bus. It acknowledges that cycle only if a gated condition is pending.

The block also holds an eight-bit output port, shown on the pins in inverted form. It holds two mode bytes that share one address and are reached through an internal pointer.

The read data bus and its enable are separate outputs. The enable tells the surrounding logic when to drive the shared lines. The acknowledge and request outputs use open-drain meaning: 0 pulls the line low, 1 leaves it released.

Top module: `cpu_irq_frontend`

## Requirements
- R1: While `rst_n` is low, and after it, the mask, status and port registers read 0 and the vector register reads 0x0F. `out_pins` is 0xFF, and `irq_n` and `dtack_n` are 1 (released).
- R2: A register cycle is recognised at the first clock edge at which `sel_n` is low. `dtack_n` goes low after that edge. It stays low while `sel_n` stays low, and returns high after the first edge at which both `sel_n` and `irq_ack_n` are high. Each held select performs exactly one access.
- R3: `rdata_oe` is high only while `dtack_n` is low during a read, or during an acknowledged interrupt-acknowledge cycle. It drops in the same cycle that `sel_n` (or `irq_ack_n`) goes high.
- R4: The address map is as follows:
  - 0: mode bytes (read/write)
  - 1: status (read) and command (write)
  - 2: mask (read/write)
  - 3: vector (read/write)
  - 4: port value (read)
  - 5: port bit-set (write)
  - 6: port bit-clear (write)
- R5: A write to address 5 sets each port bit written as 1. A write to address 6 clears each port bit written as 1. Bits written as 0 are unchanged, and `out_pins` is always the inverse of the port register.
- R6: Status bit i equals `irq_src[i]` as sampled at the previous clock edge. Reading the status register does not change it.
- R7: `irq_n` is low exactly when some status bit and the matching mask bit are both 1. With a zero mask it stays high.
- R8: If `irq_ack_n` is sampled low with `sel_n` high and an interrupt pending, `dtack_n` goes low after that edge and `rdata` carries the vector with `rdata_oe` high. The acknowledge is released after `irq_ack_n` returns high.
- R9: If `irq_ack_n` is low while no interrupt is pending, `dtack_n` stays high and `rdata_oe` stays low.
- R10: After reset, the first access to address 0 reaches mode byte 1 and every later access reaches mode byte 2. Writing a value with bit 0 set to address 1 returns the pointer to mode byte 1.
- R11: Addresses 7 to 15 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 4 | Register address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data / vector to host |
| rdata_oe | output | 1 | Drive enable for the shared data lines |
| dtack_n | output | 1 | Transfer acknowledge, 0 = pulled low, 1 = released |
| irq_ack_n | input | 1 | Active-low interrupt-acknowledge cycle |
| irq_src | input | 8 | Level inputs for the eight conditions |
| irq_n | output | 1 | Interrupt request, 0 = pulled low, 1 = released |
| out_pins | output | 8 | Output port pins, inverse of port register |

## Verification
The bench holds the select for several clocks. A design that re-ran the access on every clock would advance the mode pointer twice or re-apply writes, and the pointer test exposes that. Interrupt-acknowledge cycles are run both with and without a pending gated condition; a block that always acknowledged would drive a stale vector onto the bus. The bench reads the status register repeatedly and then the request line, so a design that cleared status on read would release the request. It also writes set and clear masks with mixed bits, which catches a port that overwrites rather than merges. It checks that the data-bus enable drops within the cycle the select is released; a registered enable would still drive the bus there and would be caught.

// File: rtl/cpu_irq_frontend.sv
module cpu_irq_frontend (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       rd_wr,
  input  logic [3:0] reg_addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rdata_oe,
  output logic       dtack_n,
  input  logic       irq_ack_n,
  input  logic [7:0] irq_src,
  output logic       irq_n,
  output logic [7:0] out_pins
);
  localparam logic [3:0] A_MODE = 4'd0, A_STAT = 4'd1, A_MASK = 4'd2, A_VEC = 4'd3,
                         A_PORT = 4'd4, A_PSET = 4'd5, A_PCLR = 4'd6;
  localparam logic [7:0] VEC_RST = 8'h0F;

  typedef enum logic [1:0] {C_IDLE, C_RD, C_WR, C_IACK} cyc_t;
  cyc_t cyc;

  logic [7:0] mode1, mode2, stat_q, mask_q, vec_q, port_q, rdata_q;
  logic       ptr2, pending, start_reg, start_iack;
  logic [7:0] rd_mux;

  assign pending    = |(stat_q & mask_q);
  assign irq_n      = ~pending;
  assign out_pins   = ~port_q;
  assign dtack_n    = (cyc == C_IDLE);
  assign rdata      = rdata_q;
  assign rdata_oe   = (!sel_n && cyc == C_RD) || (!irq_ack_n && cyc == C_IACK);
  assign start_reg  = (cyc == C_IDLE) && !sel_n;
  assign start_iack = (cyc == C_IDLE) && sel_n && !irq_ack_n && pending;

  always_comb begin
    case (reg_addr)
      A_MODE:  rd_mux = ptr2 ? mode2 : mode1;
      A_STAT:  rd_mux = stat_q;
      A_MASK:  rd_mux = mask_q;
      A_VEC:   rd_mux = vec_q;
      A_PORT:  rd_mux = port_q;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= irq_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= C_IDLE;
      rdata_q <= 8'h00;
    end else begin
      case (cyc)
        C_IDLE: begin
          if (start_reg) begin
            cyc     <= rd_wr ? C_RD : C_WR;
            rdata_q <= rd_wr ? rd_mux : 8'h00;
          end else if (start_iack) begin
            cyc     <= C_IACK;
            rdata_q <= vec_q;
          end
        end
        C_RD, C_WR: if (sel_n) cyc <= C_IDLE;
        default:    if (irq_ack_n) cyc <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1  <= 8'h00;
      mode2  <= 8'h00;
      ptr2   <= 1'b0;
      mask_q <= 8'h00;
      vec_q  <= VEC_RST;
      port_q <= 8'h00;
    end else if (start_reg) begin
      if (reg_addr == A_MODE) begin
        ptr2 <= 1'b1;
        if (!rd_wr) begin
          if (ptr2) mode2 <= wdata;
          else      mode1 <= wdata;
        end
      end
      if (!rd_wr) begin
        case (reg_addr)
          A_STAT:  if (wdata[0]) ptr2 <= 1'b0;
          A_MASK:  mask_q <= wdata;
          A_VEC:   vec_q  <= wdata;
          A_PSET:  port_q <= port_q | wdata;
          A_PCLR:  port_q <= port_q & ~wdata;
          default: ;
        endcase
      end
    end
  end

  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && irq_ack_n) |=> dtack_n);
  assert_oe_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !dtack_n);
  assert_port_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_wr && reg_addr == A_PSET && dtack_n) |=>
      (((~out_pins) & $past(wdata)) == $past(wdata)));
  assert_port_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !rd_wr && reg_addr == A_PCLR && dtack_n) |=>
      ((out_pins & $past(wdata)) == $past(wdata)));
  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> irq_n);
  assert_no_idle_iack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_ack_n && sel_n && irq_n && dtack_n) |=> dtack_n);
endmodule

// File: tb/cpu_irq_frontend_test.sv
module cpu_irq_frontend_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic       rd_wr = 1'b1;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic       dtack_n;
  logic       irq_ack_n = 1'b1;
  logic [7:0] irq_src = 8'h00;
  logic       irq_n;
  logic [7:0] out_pins;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cpu_irq_frontend uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr), .reg_addr(reg_addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .dtack_n(dtack_n),
    .irq_ack_n(irq_ack_n), .irq_src(irq_src), .irq_n(irq_n), .out_pins(out_pins)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); sel_n = 1'b0; rd_wr = 1'b0; reg_addr = a; wdata = d;
    @(negedge clk); chk("R2 write ack", {7'd0, dtack_n}, 8'd0);
    sel_n = 1'b1;
    @(negedge clk); chk("R2 write release", {7'd0, dtack_n}, 8'd1);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); sel_n = 1'b0; rd_wr = 1'b1; reg_addr = a;
    @(negedge clk); chk("R3 read oe", {6'd0, rdata_oe, dtack_n}, 8'b10);
    d = rdata;
    sel_n = 1'b1; #1;
    chk("R3 oe drop", {7'd0, rdata_oe}, 8'd0);
    @(negedge clk); chk("R2 read release", {7'd0, dtack_n}, 8'd1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 pins", out_pins, 8'hFF);
    chk("R1 irq/ack", {6'd0, irq_n, dtack_n}, 8'b11);
    bus_rd(4'd3, d); chk("R1 vector", d, 8'h0F);
    bus_rd(4'd2, d); chk("R1 mask", d, 8'h00);
    bus_rd(4'd1, d); chk("R1 status", d, 8'h00);
    bus_rd(4'd4, d); chk("R1 port", d, 8'h00);
  endtask

  task automatic t_handshake;
    logic [7:0] d;
    @(negedge clk); sel_n = 1'b0; rd_wr = 1'b0; reg_addr = 4'd2; wdata = 8'h5A;
    chk("R2 not early", {7'd0, dtack_n}, 8'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R2 ack held", {7'd0, dtack_n}, 8'd0);
    end
    sel_n = 1'b1;
    @(negedge clk); chk("R2 released", {7'd0, dtack_n}, 8'd1);
    bus_rd(4'd2, d); chk("R4 mask rw", d, 8'h5A);
    bus_wr(4'd3, 8'hC4);
    bus_rd(4'd3, d); chk("R4 vector rw", d, 8'hC4);
    bus_wr(4'd2, 8'h00);
  endtask

  task automatic t_port;
    logic [7:0] d;
    bus_wr(4'd5, 8'hA5);
    chk("R5 set pins", out_pins, 8'h5A);
    bus_wr(4'd5, 8'h0F);
    bus_rd(4'd4, d); chk("R5 set merge", d, 8'hAF);
    bus_wr(4'd6, 8'h81);
    bus_rd(4'd4, d); chk("R5 clear merge", d, 8'h2E);
    chk("R5 pins inverse", out_pins, 8'hD1);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); irq_src = 8'h24;
    @(negedge clk); chk("R7 masked off", {7'd0, irq_n}, 8'd1);
    bus_rd(4'd1, d); chk("R6 status", d, 8'h24);
    bus_wr(4'd2, 8'h04);
    chk("R7 irq low", {7'd0, irq_n}, 8'd0);
    bus_rd(4'd1, d); bus_rd(4'd1, d);
    chk("R6 read no clear", d, 8'h24);
    chk("R7 still low", {7'd0, irq_n}, 8'd0);
    @(negedge clk); irq_src = 8'h20;
    @(negedge clk); chk("R7 source gone", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_iack;
    @(negedge clk); irq_src = 8'h04;
    @(negedge clk); chk("R7 pending", {7'd0, irq_n}, 8'd0);
    irq_ack_n = 1'b0;
    @(negedge clk);
    chk("R8 ack", {6'd0, rdata_oe, dtack_n}, 8'b10);
    chk("R8 vector", rdata, 8'hC4);
    @(negedge clk); chk("R8 held", {7'd0, dtack_n}, 8'd0);
    irq_ack_n = 1'b1; #1;
    chk("R3 iack oe drop", {7'd0, rdata_oe}, 8'd0);
    @(negedge clk); chk("R8 release", {7'd0, dtack_n}, 8'd1);
  endtask

  task automatic t_iack_none;
    @(negedge clk); irq_src = 8'h00;
    @(negedge clk); chk("R9 no pending", {7'd0, irq_n}, 8'd1);
    irq_ack_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R9 no ack", {6'd0, rdata_oe, dtack_n}, 8'b01);
    end
    irq_ack_n = 1'b1;
  endtask

  task automatic t_mode;
    logic [7:0] d;
    @(negedge clk); sel_n = 1'b0; rd_wr = 1'b0; reg_addr = 4'd0; wdata = 8'h11;
    repeat (3) @(negedge clk);
    sel_n = 1'b1;
    bus_wr(4'd0, 8'h22);
    bus_wr(4'd0, 8'h33);
    bus_rd(4'd0, d); chk("R10 stays on second", d, 8'h33);
    bus_wr(4'd1, 8'h01);
    bus_rd(4'd0, d); chk("R10 first after cmd", d, 8'h11);
    bus_rd(4'd0, d); chk("R10 advanced", d, 8'h33);
    bus_wr(4'd1, 8'h00);
    bus_rd(4'd0, d); chk("R10 bit0 clear no reset", d, 8'h33);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_wr(4'd9, 8'hFF);
    bus_wr(4'd15, 8'hFF);
    bus_rd(4'd9, d); chk("R11 unmapped read", d, 8'h00);
    bus_rd(4'd2, d); chk("R11 mask untouched", d, 8'h04);
    bus_rd(4'd3, d); chk("R11 vector untouched", d, 8'hC4);
    bus_rd(4'd4, d); chk("R11 port untouched", d, 8'h2E);
  endtask

  initial begin
    #1;
    chk("R1 pins in reset", out_pins, 8'hFF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_handshake();
    t_port();
    t_status();
    t_iack();
    t_iack_none();
    t_mode();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule